// File: doc/BRIEF.md
# DMA descriptor ring consumer

This block walks a ring of two-word DMA descriptors, one slot at a time. A host fills the slots through a plain write port into a small descriptor store inside the block. The block looks at the slot under its head index. A slot counts as live only when its generation bit matches the generation the consumer expects next. A live slot is decoded and handed to a downstream data mover as a single transfer command. The command carries the virtual address, the IO-side address, the byte count, the buffer size, and the chain and notify flags. Only one command is outstanding at any time.

The transfer length is written in one of two ways. It is either a raw byte count or a power-of-two code. The buffer size comes from an eight-entry table whose entries are not all powers of two. A reserved length code is rejected, and so is a chain flag on a pull-direction ring. In either case the slot is consumed with a one-cycle error pulse and no command is issued. When the mover signals done, the head moves on, and a one-cycle completion interrupt fires if that descriptor asked for one. Each time the head wraps from the last slot to slot 0, the expected generation flips.

The controller has two states. In ST_POLL it inspects the head slot. In ST_BUSY a command is outstanding. Its transitions are:
- idle-wait (ST_POLL to ST_POLL): the slot is not live.
- reject (ST_POLL to ST_POLL): the slot is live but bad; the head advances and the error pulse fires.
- accept (ST_POLL to ST_BUSY): the slot is live and good; the command is latched.
- hold (ST_BUSY to ST_BUSY): the mover has not yet signalled done.
- retire (ST_BUSY to ST_POLL): done arrives; the head advances and the interrupt fires if it was requested.

Top module: `desc_ring_consumer`

## Requirements
- R1: After reset the head is slot 0, the expected generation is 1, and `cmd_valid`, `done_irq` and `desc_err` are low. A store holding all zeros issues no command.
- R2: A slot is live only when word-0 bit 63 (generation) equals the expected generation. A slot that is not live issues no command and no error, however long it waits.
- R3: Word-0 fields, counted from bit 0, are:
  - bits 41:0: virtual address, sent to `cmd_va`;
  - bits 44:42: buffer-size code;
  - bit 45: chain flag, sent to `cmd_chain`;
  - bit 46: notify flag, sent to `cmd_notify`;
  - bit 47: size mode;
  - bits 61:48: length field;
  - bit 62: reserved and ignored.

  Word 1 is sent unchanged to `cmd_io_addr`.
- R4: With size mode 0, `cmd_bytes` equals the 14-bit length field.
- R5: With size mode 1 and a length code N from 0 to 6, `cmd_bytes` is 2^(N+14): 16384 for N=0 and 1048576 for N=6.
- R6: With size mode 1 and a length code of 7 or more, the slot raises `desc_err` for exactly one cycle, issues no command, and is consumed, so the next slot is processed next.
- R7: Buffer-size codes 0 to 7 give `cmd_buf_bytes` of 128, 256, 512, 1024, 1664, 4096, 10368 and 16384.
- R8: With `pull_mode`=1, a set chain flag is rejected exactly as in R6. With `pull_mode`=0, a set chain flag passes through to `cmd_chain`.
- R9: Once `cmd_valid` rises, it stays high and every command field stays stable until the cycle after `mover_done` is sampled high. `cmd_valid` then falls.
- R10: `done_irq` is high for exactly one cycle, the cycle after `mover_done` is accepted, and only if the notify flag of that descriptor was set.
- R11: When the head wraps from slot DEPTH-1 to slot 0, the expected generation flips. After the wrap, a slot still carrying the old generation is not live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe into the descriptor store |
| host_wr_slot | input | IDX_W | Slot index written |
| host_wr_hi | input | 1 | 0 writes word 0, 1 writes word 1 |
| host_wr_data | input | 64 | Write data |
| pull_mode | input | 1 | Static ring direction: 1 for pull, 0 for push |
| cmd_valid | output | 1 | Transfer command outstanding |
| cmd_va | output | 42 | Virtual address |
| cmd_io_addr | output | 64 | IO-side address |
| cmd_bytes | output | 21 | Decoded byte count |
| cmd_buf_bytes | output | 15 | Decoded buffer size in bytes |
| cmd_chain | output | 1 | Chain flag |
| cmd_notify | output | 1 | Notify flag |
| mover_done | input | 1 | Mover signals the transfer is complete |
| done_irq | output | 1 | One-cycle completion interrupt |
| desc_err | output | 1 | One-cycle pulse for a rejected descriptor |

## Verification
A head index that is off by one shows up on the next command. The ports then present fields from the wrong slot, or issue nothing at all, within a cycle of the first live slot being written. A generation flip that is wrong or missing shows up only after the first wrap. Either a stale slot is accepted again, or a fresh one is ignored forever. A stale-slot probe straight after the wrap exposes it within a dozen cycles. A lost notify bit, or a controller that leaves ST_BUSY too early, is visible as a bad `done_irq` or a dropped `cmd_valid` in the cycle right after `mover_done`.

// File: rtl/dring_pkg.sv
package dring_pkg;
    localparam int VA_W    = 42;
    localparam int IO_W    = 64;
    localparam int BYTES_W = 21;
    localparam int BUF_W   = 15;
    localparam int W0_W    = 63; // word 0 with the reserved bit dropped

    typedef enum logic {
        ST_POLL = 1'b0,
        ST_BUSY = 1'b1
    } ring_state_t;

    typedef struct packed {
        logic [VA_W-1:0]    va;
        logic [IO_W-1:0]    io_addr;
        logic [BYTES_W-1:0] bytes;
        logic [BUF_W-1:0]   buf_bytes;
        logic               chain;
        logic               notify;
    } xfer_cmd_t;
endpackage

// File: rtl/dring_mem.sv
module dring_mem #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_hi,
    input  logic [63:0]                   wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [dring_pkg::W0_W-1:0]    rd_w0,
    output logic [63:0]                   rd_w1
);
    import dring_pkg::*;

    logic [W0_W-1:0] lo_q [DEPTH];
    logic [63:0]     hi_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_hi) hi_q[wr_idx] <= wr_data;
            else       lo_q[wr_idx] <= {wr_data[63], wr_data[61:0]};
        end
    end

    assign rd_w0 = lo_q[rd_idx];
    assign rd_w1 = hi_q[rd_idx];
endmodule

// File: rtl/dring_decode.sv
module dring_decode
    import dring_pkg::*;
(
    input  logic [W0_W-1:0] w0,
    input  logic [63:0]     w1,
    input  logic            pull_mode,
    output xfer_cmd_t       cmd,
    output logic            gen,
    output logic            bad
);
    logic [2:0]  bsz;
    logic        smod;
    logic [13:0] len;

    assign bsz  = w0[44:42];
    assign smod = w0[47];
    assign len  = w0[61:48];
    assign gen  = w0[62];

    always_comb begin
        cmd.va      = w0[VA_W-1:0];
        cmd.io_addr = w1;
        cmd.chain   = w0[45];
        cmd.notify  = w0[46];
        if (smod) cmd.bytes = BYTES_W'(1) << (5'd14 + {2'b00, len[2:0]});
        else      cmd.bytes = BYTES_W'(len);
        unique case (bsz)
            3'd0: cmd.buf_bytes = BUF_W'(128);
            3'd1: cmd.buf_bytes = BUF_W'(256);
            3'd2: cmd.buf_bytes = BUF_W'(512);
            3'd3: cmd.buf_bytes = BUF_W'(1024);
            3'd4: cmd.buf_bytes = BUF_W'(1664);
            3'd5: cmd.buf_bytes = BUF_W'(4096);
            3'd6: cmd.buf_bytes = BUF_W'(10368);
            3'd7: cmd.buf_bytes = BUF_W'(16384);
        endcase
        bad = (smod && (len > 14'd6)) || (pull_mode && w0[45]);
    end
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pull_mode,
    input  dring_pkg::xfer_cmd_t  slot_cmd,
    input  logic                  slot_gen,
    input  logic                  slot_bad,
    input  logic                  mover_done,
    output logic [IDX_W-1:0]      head,
    output dring_pkg::xfer_cmd_t  cmd_q,
    output logic                  cmd_valid,
    output logic                  done_irq,
    output logic                  desc_err
);
    import dring_pkg::*;

    ring_state_t state, state_nx;
    logic        exp_gen;
    logic        live, do_accept, do_reject, do_retire, advance;

    assign live      = (slot_gen == exp_gen);
    assign do_accept = (state == ST_POLL) && live && !slot_bad;
    assign do_reject = (state == ST_POLL) && live &&  slot_bad;
    assign do_retire = (state == ST_BUSY) && mover_done;
    assign advance   = do_reject || do_retire;
    assign cmd_valid = (state == ST_BUSY);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POLL: if (do_accept) state_nx = ST_BUSY;
            ST_BUSY: if (do_retire) state_nx = ST_POLL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POLL;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head     <= '0;
            exp_gen  <= 1'b1;
            cmd_q    <= '0;
            done_irq <= 1'b0;
            desc_err <= 1'b0;
        end else begin
            done_irq <= do_retire && cmd_q.notify;
            desc_err <= do_reject;
            if (do_accept) cmd_q <= slot_cmd;
            if (advance) begin
                head <= head + 1'b1;
                if (head == IDX_W'(DEPTH - 1)) exp_gen <= ~exp_gen;
            end
        end
    end

    // R9: command held stable until done is accepted
    a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mover_done) |=> (cmd_valid && $stable(cmd_q)));

    // R10: interrupt only right after an accepted done
    a_r10_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> ($past(mover_done) && !cmd_valid));

    // R11: head steps by one and generation flips on wrap
    a_r11_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (head != $past(head)) |-> (head == IDX_W'($past(head) + 1'b1)));

    a_r11_gen_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(head) == IDX_W'(DEPTH - 1) && head == '0) |-> (exp_gen != $past(exp_gen)));

    // R8: pull ring never issues a chained command
    a_r8_pull_no_chain: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_valid) && pull_mode) |-> !cmd_q.chain);

    // R6: error and interrupt pulses never coincide, error never during a command
    a_r6_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_err, done_irq}) && !(desc_err && cmd_valid));
endmodule

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_wr_en,
    input  logic [IDX_W-1:0]                host_wr_slot,
    input  logic                            host_wr_hi,
    input  logic [63:0]                     host_wr_data,
    input  logic                            pull_mode,
    output logic                            cmd_valid,
    output logic [dring_pkg::VA_W-1:0]      cmd_va,
    output logic [dring_pkg::IO_W-1:0]      cmd_io_addr,
    output logic [dring_pkg::BYTES_W-1:0]   cmd_bytes,
    output logic [dring_pkg::BUF_W-1:0]     cmd_buf_bytes,
    output logic                            cmd_chain,
    output logic                            cmd_notify,
    input  logic                            mover_done,
    output logic                            done_irq,
    output logic                            desc_err
);
    import dring_pkg::*;

    logic [IDX_W-1:0] head;
    logic [W0_W-1:0]  rd_w0;
    logic [63:0]      rd_w1;
    xfer_cmd_t        slot_cmd, cmd_q;
    logic             slot_gen, slot_bad;

    dring_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr_en), .wr_idx(host_wr_slot), .wr_hi(host_wr_hi),
        .wr_data(host_wr_data), .rd_idx(head),
        .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    dring_decode u_dec (
        .w0(rd_w0), .w1(rd_w1), .pull_mode(pull_mode),
        .cmd(slot_cmd), .gen(slot_gen), .bad(slot_bad)
    );

    dring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pull_mode(pull_mode),
        .slot_cmd(slot_cmd), .slot_gen(slot_gen), .slot_bad(slot_bad),
        .mover_done(mover_done), .head(head), .cmd_q(cmd_q),
        .cmd_valid(cmd_valid), .done_irq(done_irq), .desc_err(desc_err)
    );

    assign cmd_va        = cmd_q.va;
    assign cmd_io_addr   = cmd_q.io_addr;
    assign cmd_bytes     = cmd_q.bytes;
    assign cmd_buf_bytes = cmd_q.buf_bytes;
    assign cmd_chain     = cmd_q.chain;
    assign cmd_notify    = cmd_q.notify;
endmodule

// File: tb/desc_ring_consumer_test.sv
module desc_ring_consumer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic host_wr_en = 0, host_wr_hi = 0, pull_mode = 0, mover_done = 0;
    logic [IDX_W-1:0] host_wr_slot = '0;
    logic [63:0] host_wr_data = '0;
    logic cmd_valid, cmd_chain, cmd_notify, done_irq, desc_err;
    logic [41:0] cmd_va;
    logic [63:0] cmd_io_addr;
    logic [20:0] cmd_bytes;
    logic [14:0] cmd_buf_bytes;

    desc_ring_consumer #(.DEPTH(DEPTH)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        err;
        logic [41:0] va;
        logic [63:0] io;
        logic [20:0] bytes;
        logic [14:0] bufb;
        logic        chain;
        logic        notify;
    } exp_t;

    exp_t exp_q[$];
    int total = 0, bad = 0;
    bit finished = 0;
    int tail = 0;
    bit tgen = 1;
    int buf_tab[8] = '{128, 256, 512, 1024, 1664, 4096, 10368, 16384};

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(input int slot, input bit hi, input logic [63:0] d);
        @(negedge clk);
        host_wr_en = 1; host_wr_slot = IDX_W'(slot); host_wr_hi = hi; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    function automatic logic [63:0] mk_w0(input bit g, input logic [13:0] len, input bit smod,
                                          input bit notify, input bit chain, input logic [2:0] bsz,
                                          input logic [41:0] va);
        return {g, 1'b1, len, smod, notify, chain, bsz, va}; // bit 62 set: reserved, ignored (R3)
    endfunction

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // driver: push expected item, then write word 1 and word 0 of the tail slot
    task automatic put_desc(input logic [41:0] va, input logic [63:0] io, input logic [2:0] bsz,
                            input bit chain, input bit notify, input bit smod, input logic [13:0] len);
        exp_t e;
        drain();
        e.err    = (smod && len > 6) || (pull_mode && chain);
        e.va     = va;
        e.io     = io;
        e.bytes  = smod ? 21'(1 << (len + 14)) : 21'(len);
        e.bufb   = 15'(buf_tab[bsz]);
        e.chain  = chain;
        e.notify = notify;
        exp_q.push_back(e);
        wr(tail, 1, io);
        wr(tail, 0, mk_w0(tgen, len, smod, notify, chain, bsz, va));
        tail++;
        if (tail == DEPTH) begin tail = 0; tgen = ~tgen; end
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected command", 1, 0);
                    mover_done = 1; @(negedge clk); mover_done = 0;
                end else begin
                    e = exp_q[0];
                    check(!e.err, "R6/R8 command issued for rejected slot", 1, 0);
                    check(cmd_va == e.va, "R3 va", cmd_va, e.va);
                    check(cmd_io_addr == e.io, "R3 io", cmd_io_addr, e.io);
                    check(cmd_chain == e.chain, "R8 chain", cmd_chain, e.chain);
                    check(cmd_notify == e.notify, "R3 notify", cmd_notify, e.notify);
                    check(cmd_bytes == e.bytes, "R4/R5 bytes", cmd_bytes, e.bytes);
                    check(cmd_buf_bytes == e.bufb, "R7 buffer", cmd_buf_bytes, e.bufb);
                    repeat (2) @(negedge clk);
                    check(cmd_valid && cmd_bytes == e.bytes && cmd_va == e.va, "R9 hold",
                          cmd_valid, 1);
                    check(done_irq == 0, "R10 irq before done", done_irq, 0);
                    mover_done = 1;
                    @(negedge clk);
                    mover_done = 0;
                    check(done_irq == e.notify, "R10 irq", done_irq, e.notify);
                    check(cmd_valid == 0, "R9 release", cmd_valid, 0);
                    @(negedge clk);
                    check(done_irq == 0, "R10 pulse width", done_irq, 0);
                    void'(exp_q.pop_front());
                end
            end else if (desc_err) begin
                if (exp_q.size() == 0) check(0, "R6 unexpected error", 1, 0);
                else begin
                    e = exp_q[0];
                    check(e.err, "R6/R8 error pulse", 1, e.err);
                    @(negedge clk);
                    check(desc_err == 0, "R6 pulse width", desc_err, 0);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        check(done_irq == 0 && desc_err == 0, "R1 pulses", {done_irq, desc_err}, 0);
        repeat (10) @(negedge clk);
        check(cmd_valid == 0 && desc_err == 0, "R1 zero ring empty", cmd_valid, 0);

        // R2: slot 0 with wrong generation stays idle
        wr(0, 1, 64'h1234);
        wr(0, 0, mk_w0(1'b0, 14'd100, 1'b0, 1'b1, 1'b0, 3'd1, 42'h55));
        repeat (12) @(negedge clk);
        check(cmd_valid == 0 && desc_err == 0, "R2 stale slot ignored", cmd_valid, 0);

        put_desc(42'h2_0000_1234, 64'hDEAD_BEEF_0000_1000, 3'd4, 0, 1, 0, 14'd1500); // R4
        put_desc(42'h0_0ABC_0000, 64'h0000_0001_0000_0000, 3'd6, 0, 0, 1, 14'd0);    // R5 16KB
        put_desc(42'h3_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, 0, 1, 1, 14'd6);    // R5 1MB
        put_desc(42'h1, 64'h2, 3'd0, 0, 1, 1, 14'd7);                                // R6
        put_desc(42'h2, 64'h3, 3'd0, 0, 1, 1, 14'h3FFF);                             // R6
        drain(); pull_mode = 1;
        put_desc(42'h4, 64'h5, 3'd2, 1, 1, 0, 14'd64);                               // R8 reject
        put_desc(42'h6, 64'h7, 3'd3, 0, 1, 0, 14'd64);                               // R8 pull ok
        drain(); pull_mode = 0;
        put_desc(42'h8, 64'h9, 3'd5, 1, 0, 0, 14'd16383);                            // R8 push chain
        for (int b = 0; b < 8; b++)                                                   // R7 table
            put_desc(42'(b * 7 + 1), 64'(b * 1000), 3'(b), 0, b[0], 1, 14'(b % 7));
        drain();

        // R11: after wrap, slot 0 with old generation (1) is stale
        check(tail == 0 && tgen == 0, "R11 bench wrapped", tail, 0);
        wr(0, 0, mk_w0(1'b1, 14'd10, 1'b0, 1'b1, 1'b0, 3'd0, 42'h77));
        repeat (12) @(negedge clk);
        check(cmd_valid == 0 && desc_err == 0, "R11 old generation ignored", cmd_valid, 0);
        put_desc(42'h99, 64'hAA, 3'd1, 0, 1, 0, 14'd20);                             // R11 new gen
        drain();

        finish_run();
    end
endmodule